// File: doc/BRIEF.md
# Scatter-Gather Write Address Sequencer

This block takes a continuous stream of wide data words from user logic and cuts it into memory-write bursts. Each burst is aimed at one of several destination buffers that the host describes in a small on-chip table. The host fills the table through a simple register-write port. Each row holds a 64-bit destination address and a byte length. The host then sets a run bit. The sequencer walks the valid rows in index order without further host action. It emits each burst as a header (address and beat count) carried alongside its data beats on one output channel. It sets a completion bit for each row whose length has been consumed.

Bursts are capped at a maximum size and are never allowed to straddle a page boundary, so a burst can end early at a page edge or at the end of a row. A wrap mode loops the walk from the last valid row back to the first. This lets two rows act as an endless pair of alternating buffers. Clearing the run bit ends the walk cleanly at the end of the burst in progress. Stalls on the output side pass straight back to the input stream, so no word is dropped or sent twice.

Top module: `sgw_seq_top`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `out_valid` is 0, `s_ready` is 0 and `done_mask` is all zero, whatever `s_valid` does.
- R2: A register write to the control word (`cfg_addr` bit 6 set) with bit 0 = 1 while idle starts a walk at the lowest-indexed valid row. A row is valid when its length is non-zero. Row `i` field `f` lives at `cfg_addr = {1'b0, i[3:0], f[1:0]}`, where f=0 is address bits 31:0, f=1 is address bits 63:32 and f=2 is the length in bytes. If no row is valid, the start is ignored.
- R3: Every burst carries between 1 and 8 beats of 32 bytes. `out_beats` gives its beat count, `out_sop` marks its first beat and `out_eop` its last, and `out_addr` is its byte address on all of its beats.
- R4: No burst crosses a 4096-byte address boundary; a burst ends early at such a boundary.
- R5: When a row's length is used up, bit `i` of `done_mask` is set and the walk continues at the next higher valid row, skipping invalid rows. When none is left, `busy` drops.
- R6: With control bit 1 (wrap) set, the walk continues from the highest valid row back to the lowest valid row and runs until stopped.
- R7: When `out_ready` is 0, `s_ready` is 0 and the burst state holds. Every input word is emitted exactly once, in order.
- R8: Writing the control word with bit 0 = 0 during a walk stops it after the current burst's last beat, never mid-burst.
- R9: Writing a row's length clears that row's `done_mask` bit. A start clears all bits of `done_mask`.
- R10: Bits 4:0 of the written low address and of the length are ignored (treated as zero), so rows are 32-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address: bit 6 selects the control word, else row and field |
| cfg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Input stream word valid |
| s_ready | output | 1 | Input stream word accepted |
| s_data | input | 256 | Input stream word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | 256 | Output beat data |
| out_addr | output | 64 | Byte address of the current burst |
| out_beats | output | 4 | Beat count of the current burst |
| out_sop | output | 1 | First beat of a burst |
| out_eop | output | 1 | Last beat of a burst |
| busy | output | 1 | Walk in progress |
| done_mask | output | 16 | Per-row completion bits |

## Verification
Single-row transfers are tried across a table of start addresses and lengths. The table covers a row that is exactly one maximal burst, a short row, a row that begins just below a page edge, a row in a high address window that is split by a page edge, a row whose length is not a multiple of the cap, and rows with junk in the low bits. Together these separate the burst cap from the page split and from the end-of-row cut. Some of these rows run under irregular output stalls and input bubbles, which separates correct stall handling from data loss or duplication. Directed runs cover row skipping, wrap-around over two alternating rows, a stop request in the middle of a long row, clearing of completion bits, and a start with an empty table.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   // Field selector within one table row (register address bits 1:0)
   typedef enum logic [1:0] {
      FLD_ADDR_LO = 2'd0,
      FLD_ADDR_HI = 2'd1,
      FLD_LEN     = 2'd2,
      FLD_RSVD    = 2'd3
   } sgw_field_e;

   // Control word bit positions
   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_WRAP_BIT = 1;

   typedef enum logic {
      WK_IDLE = 1'b0,
      WK_MOVE = 1'b1
   } sgw_walk_e;

endpackage

// File: rtl/sgw_table.sv
module sgw_table
   import sgw_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int AW      = 64,
   parameter int LW      = 32,
   parameter int BEAT_SH = 5,
   parameter int IDX_W   = 4,
   parameter int CFG_AW  = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [31:0]                   cfg_wdata,
   output logic [ENTRIES-1:0][AW-1:0]    tbl_addr,
   output logic [ENTRIES-1:0][LW-1:0]    tbl_len,
   output logic [ENTRIES-1:0]            entry_valid,
   output logic [ENTRIES-1:0]            len_wr,
   output logic                          ctrl_run,
   output logic                          ctrl_wrap,
   output logic                          ctrl_start
);

   logic             is_ctrl;
   logic [IDX_W-1:0] sel_idx;
   sgw_field_e       fld;

   assign is_ctrl = cfg_addr[CFG_AW-1];
   assign sel_idx = cfg_addr[IDX_W+1:2];
   assign fld     = sgw_field_e'(cfg_addr[1:0]);

   // One storage row per table entry
   for (genvar g = 0; g < ENTRIES; g++) begin : g_row
      logic [AW-1:0] addr_q;
      logic [LW-1:0] len_q;
      logic          hit;

      assign hit = cfg_we && !is_ctrl && (sel_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
         end else if (hit) begin
            case (fld)
               FLD_ADDR_LO: addr_q[31:0]    <= {cfg_wdata[31:BEAT_SH], BEAT_SH'(0)};
               FLD_ADDR_HI: addr_q[AW-1:32] <= cfg_wdata[AW-33:0];
               FLD_LEN:     len_q           <= {cfg_wdata[LW-1:BEAT_SH], BEAT_SH'(0)};
               default:     ;
            endcase
         end
      end

      assign tbl_addr[g]    = addr_q;
      assign tbl_len[g]     = len_q;
      assign entry_valid[g] = |len_q;
      assign len_wr[g]      = hit && (fld == FLD_LEN);
   end

   // Control word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_run  <= 1'b0;
         ctrl_wrap <= 1'b0;
      end else if (cfg_we && is_ctrl) begin
         ctrl_run  <= cfg_wdata[CTRL_RUN_BIT];
         ctrl_wrap <= cfg_wdata[CTRL_WRAP_BIT];
      end
   end

   assign ctrl_start = cfg_we && is_ctrl && cfg_wdata[CTRL_RUN_BIT];

endmodule

// File: rtl/sgw_next_sel.sv
module sgw_next_sel #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic [ENTRIES-1:0] entry_valid,
   input  logic [IDX_W-1:0]   cur_idx,
   input  logic               wrap,
   output logic [IDX_W-1:0]   first_idx,
   output logic               first_found,
   output logic [IDX_W-1:0]   next_idx,
   output logic               next_found
);

   // Lowest valid row overall
   always_comb begin
      first_idx   = '0;
      first_found = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!first_found && entry_valid[i]) begin
            first_idx   = IDX_W'(i);
            first_found = 1'b1;
         end
      end
   end

   // Lowest valid row above the current one, else the lowest when wrapping
   always_comb begin
      next_idx   = '0;
      next_found = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!next_found && entry_valid[i] && (i > int'(cur_idx))) begin
            next_idx   = IDX_W'(i);
            next_found = 1'b1;
         end
      end
      if (!next_found && wrap && first_found) begin
         next_idx   = first_idx;
         next_found = 1'b1;
      end
   end

endmodule

// File: rtl/sgw_burst_calc.sv
module sgw_burst_calc #(
   parameter int AW              = 64,
   parameter int LW              = 32,
   parameter int BEAT_SH         = 5,
   parameter int MAX_BURST_BYTES = 256,
   parameter int PAGE_BYTES      = 4096,
   parameter int PAGE_SH         = 12,
   parameter int BW              = 4,
   parameter bit PAGE_GUARD      = 1'b1
) (
   input  logic [AW-1:0] cur_addr,
   input  logic [LW-1:0] cur_rem,
   output logic [LW-1:0] burst_bytes,
   output logic [BW-1:0] burst_beats
);

   logic [LW-1:0] cap;

   // Variant choice: with the guard the cap also respects the next page edge
   if (PAGE_GUARD) begin : g_guard
      logic [PAGE_SH:0] to_page;
      assign to_page = (PAGE_SH+1)'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_SH-1:0]};
      assign cap = (LW'(to_page) < LW'(MAX_BURST_BYTES)) ? LW'(to_page)
                                                         : LW'(MAX_BURST_BYTES);
   end else begin : g_plain
      assign cap = LW'(MAX_BURST_BYTES);
   end

   assign burst_bytes = (cur_rem < cap) ? cur_rem : cap;
   assign burst_beats = BW'(burst_bytes >> BEAT_SH);

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
   import sgw_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int AW         = 64,
   parameter int LW         = 32,
   parameter int IDX_W      = 4,
   parameter int BW         = 4,
   parameter int BEAT_BYTES = 32,
   parameter int MAX_BEATS  = 8,
   parameter int PAGE_BYTES = 4096,
   parameter int PAGE_SH    = 12,
   parameter bit PAGE_GUARD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       run,
   input  logic [ENTRIES-1:0][AW-1:0] tbl_addr,
   input  logic [ENTRIES-1:0][LW-1:0] tbl_len,
   input  logic [ENTRIES-1:0]         len_wr,
   input  logic [IDX_W-1:0]           first_idx,
   input  logic                       first_found,
   input  logic [IDX_W-1:0]           next_idx,
   input  logic                       next_found,
   input  logic [LW-1:0]              burst_bytes,
   input  logic [BW-1:0]              burst_beats,
   output logic [IDX_W-1:0]           cur_idx,
   output logic [AW-1:0]              cur_addr,
   output logic [LW-1:0]              cur_rem,
   input  logic                       s_valid,
   output logic                       s_ready,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [AW-1:0]              out_addr,
   output logic [BW-1:0]              out_beats,
   output logic                       out_sop,
   output logic                       out_eop,
   output logic                       busy,
   output logic [ENTRIES-1:0]         done_mask
);

   sgw_walk_e          state;
   logic [BW-1:0]      beat_cnt;
   logic               hs;
   logic               last_beat;
   logic               burst_end;
   logic [LW-1:0]      new_rem;
   logic [ENTRIES-1:0] set_vec;

   assign busy      = (state == WK_MOVE);
   assign hs        = busy && s_valid && out_ready;
   assign last_beat = (beat_cnt == burst_beats - BW'(1));
   assign burst_end = hs && last_beat;
   assign new_rem   = cur_rem - burst_bytes;

   always_comb begin
      set_vec = '0;
      if (burst_end && (new_rem == '0)) set_vec[cur_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= WK_IDLE;
         beat_cnt  <= '0;
         cur_idx   <= '0;
         cur_addr  <= '0;
         cur_rem   <= '0;
         done_mask <= '0;
      end else begin
         if (start && !busy) done_mask <= '0;
         else                done_mask <= (done_mask & ~len_wr) | set_vec;

         if (!busy) begin
            if (start && first_found) begin
               state    <= WK_MOVE;
               beat_cnt <= '0;
               cur_idx  <= first_idx;
               cur_addr <= tbl_addr[first_idx];
               cur_rem  <= tbl_len[first_idx];
            end
         end else if (hs) begin
            if (!last_beat) begin
               beat_cnt <= beat_cnt + BW'(1);
            end else begin
               beat_cnt <= '0;
               if (new_rem == '0) begin
                  if (run && next_found) begin
                     cur_idx  <= next_idx;
                     cur_addr <= tbl_addr[next_idx];
                     cur_rem  <= tbl_len[next_idx];
                  end else begin
                     state <= WK_IDLE;
                  end
               end else begin
                  cur_addr <= cur_addr + AW'(burst_bytes);
                  cur_rem  <= new_rem;
                  if (!run) state <= WK_IDLE;
               end
            end
         end
      end
   end

   assign s_ready   = busy && out_ready;
   assign out_valid = busy && s_valid;
   assign out_addr  = cur_addr;
   assign out_beats = burst_beats;
   assign out_sop   = (beat_cnt == '0);
   assign out_eop   = last_beat;

   // R3: every burst spans one to MAX_BEATS beats
   p_beats_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (out_beats != '0) && (int'(out_beats) <= MAX_BEATS));

   // R4: the burst stays inside its page
   if (PAGE_GUARD) begin : g_page_chk
      p_no_page_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> (int'(out_addr[PAGE_SH-1:0]) + int'(out_beats) * BEAT_BYTES) <= PAGE_BYTES);
   end

   // R7: a stalled output freezes the burst position
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !out_ready) |=> $stable(out_addr) && $stable(beat_cnt) && busy);

   // R5: a done bit only appears right after a burst's last beat
   p_done_on_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_mask & ~$past(done_mask)) != '0) |-> $past(hs && out_eop));

   // R8: the walk only ends on a burst's last beat
   p_stop_at_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(hs && out_eop));

endmodule

// File: rtl/sgw_seq_top.sv
module sgw_seq_top
   import sgw_pkg::*;
#(
   parameter int ENTRIES         = 16,
   parameter int DW              = 256,
   parameter int AW              = 64,
   parameter int LW              = 32,
   parameter int MAX_BURST_BYTES = 256,
   parameter int PAGE_BYTES      = 4096,
   parameter bit PAGE_GUARD      = 1'b1,
   localparam int BEAT_BYTES     = DW / 8,
   localparam int BEAT_SH        = $clog2(BEAT_BYTES),
   localparam int MAX_BEATS      = MAX_BURST_BYTES / BEAT_BYTES,
   localparam int BW             = $clog2(MAX_BEATS + 1),
   localparam int IDX_W          = $clog2(ENTRIES),
   localparam int CFG_AW         = IDX_W + 3,
   localparam int PAGE_SH        = $clog2(PAGE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic [31:0]        cfg_wdata,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [DW-1:0]      s_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [DW-1:0]      out_data,
   output logic [AW-1:0]      out_addr,
   output logic [BW-1:0]      out_beats,
   output logic               out_sop,
   output logic               out_eop,
   output logic               busy,
   output logic [ENTRIES-1:0] done_mask
);

   initial begin : g_param_chk
      a_entries_pow2: assert ((1 << IDX_W) == ENTRIES && ENTRIES >= 2)
         else $error("ENTRIES must be a power of two");
      a_beat_pow2: assert ((1 << BEAT_SH) == BEAT_BYTES && BEAT_SH <= 12)
         else $error("DW must give a power-of-two beat size");
      a_burst_mult: assert (MAX_BEATS >= 1 && MAX_BEATS * BEAT_BYTES == MAX_BURST_BYTES)
         else $error("MAX_BURST_BYTES must be a multiple of the beat size");
      a_page_fit: assert ((1 << PAGE_SH) == PAGE_BYTES && PAGE_BYTES >= MAX_BURST_BYTES)
         else $error("PAGE_BYTES must be a power of two no smaller than a burst");
      a_widths: assert (AW > 32 && AW <= 64 && LW > BEAT_SH && LW <= 32)
         else $error("address or length width out of range");
   end

   logic [ENTRIES-1:0][AW-1:0] tbl_addr;
   logic [ENTRIES-1:0][LW-1:0] tbl_len;
   logic [ENTRIES-1:0]         entry_valid;
   logic [ENTRIES-1:0]         len_wr;
   logic                       ctrl_run;
   logic                       ctrl_wrap;
   logic                       ctrl_start;
   logic [IDX_W-1:0]           first_idx;
   logic                       first_found;
   logic [IDX_W-1:0]           next_idx;
   logic                       next_found;
   logic [IDX_W-1:0]           cur_idx;
   logic [AW-1:0]              cur_addr;
   logic [LW-1:0]              cur_rem;
   logic [LW-1:0]              burst_bytes;
   logic [BW-1:0]              burst_beats;

   sgw_table #(
      .ENTRIES(ENTRIES), .AW(AW), .LW(LW), .BEAT_SH(BEAT_SH),
      .IDX_W(IDX_W), .CFG_AW(CFG_AW)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .tbl_addr(tbl_addr), .tbl_len(tbl_len),
      .entry_valid(entry_valid), .len_wr(len_wr), .ctrl_run(ctrl_run),
      .ctrl_wrap(ctrl_wrap), .ctrl_start(ctrl_start)
   );

   sgw_next_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_next (
      .entry_valid(entry_valid), .cur_idx(cur_idx), .wrap(ctrl_wrap),
      .first_idx(first_idx), .first_found(first_found),
      .next_idx(next_idx), .next_found(next_found)
   );

   sgw_burst_calc #(
      .AW(AW), .LW(LW), .BEAT_SH(BEAT_SH), .MAX_BURST_BYTES(MAX_BURST_BYTES),
      .PAGE_BYTES(PAGE_BYTES), .PAGE_SH(PAGE_SH), .BW(BW), .PAGE_GUARD(PAGE_GUARD)
   ) u_calc (
      .cur_addr(cur_addr), .cur_rem(cur_rem),
      .burst_bytes(burst_bytes), .burst_beats(burst_beats)
   );

   sgw_walker #(
      .ENTRIES(ENTRIES), .AW(AW), .LW(LW), .IDX_W(IDX_W), .BW(BW),
      .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(PAGE_BYTES),
      .PAGE_SH(PAGE_SH), .PAGE_GUARD(PAGE_GUARD)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(ctrl_start), .run(ctrl_run),
      .tbl_addr(tbl_addr), .tbl_len(tbl_len), .len_wr(len_wr),
      .first_idx(first_idx), .first_found(first_found),
      .next_idx(next_idx), .next_found(next_found),
      .burst_bytes(burst_bytes), .burst_beats(burst_beats),
      .cur_idx(cur_idx), .cur_addr(cur_addr), .cur_rem(cur_rem),
      .s_valid(s_valid), .s_ready(s_ready), .out_valid(out_valid),
      .out_ready(out_ready), .out_addr(out_addr), .out_beats(out_beats),
      .out_sop(out_sop), .out_eop(out_eop), .busy(busy), .done_mask(done_mask)
   );

   assign out_data = s_data;

endmodule

// File: tb/sgw_seq_top_bench.sv
`timescale 1ns/1ps
module sgw_seq_top_bench;

   typedef struct packed {
      logic [63:0] base;
      logic [31:0] len;
      logic        tog;
      logic [7:0]  nb;
      logic [3:0]  fb;
      logic [3:0]  lb;
      logic [63:0] faddr;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{64'h1000,        32'd256,  1'b0, 8'd1, 4'd8, 4'd8, 64'h1000},
      '{64'h1000,        32'd96,   1'b1, 8'd1, 4'd3, 4'd3, 64'h1000},
      '{64'h1F80,        32'd512,  1'b1, 8'd3, 4'd4, 4'd4, 64'h1F80},
      '{64'h2_0000_0FE0, 32'd64,   1'b0, 8'd2, 4'd1, 4'd1, 64'h2_0000_0FE0},
      '{64'h0,           32'd1000, 1'b1, 8'd4, 4'd8, 4'd7, 64'h0},
      '{64'h1007,        32'd64,   1'b0, 8'd1, 4'd2, 4'd2, 64'h1000}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [6:0]   cfg_addr = '0;
   logic [31:0]  cfg_wdata = '0;
   logic         s_valid;
   logic         s_ready;
   logic [255:0] s_data;
   logic         out_valid;
   logic         out_ready;
   logic [255:0] out_data;
   logic [63:0]  out_addr;
   logic [3:0]   out_beats;
   logic         out_sop;
   logic         out_eop;
   logic         busy;
   logic [15:0]  done_mask;

   always #10 clk = ~clk;

   sgw_seq_top u_sgw_seq_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_addr(out_addr), .out_beats(out_beats),
      .out_sop(out_sop), .out_eop(out_eop), .busy(busy), .done_mask(done_mask)
   );

   int          total = 0;
   int          bad = 0;
   int          cyc = 0;
   logic        src_on = 1'b0;
   logic        tog = 1'b0;
   logic [31:0] word_cnt = '0;
   int          r7_bad = 0;
   int          nlog = 0;
   logic [63:0] log_addr [512];
   logic [3:0]  log_beats [512];
   logic        log_sop [512];
   logic        log_eop [512];
   logic [31:0] log_data [512];

   assign s_valid   = src_on && !(tog && (cyc % 5 == 0));
   assign out_ready = !tog || (cyc % 3 != 0);
   assign s_data    = {8{word_cnt}};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (s_valid && s_ready) word_cnt <= word_cnt + 32'd1;
   end

   always @(negedge clk) begin
      if (rst_n && !out_ready && s_ready) r7_bad++;
      if (rst_n && out_valid && out_ready && nlog < 512) begin
         log_addr[nlog]  = out_addr;
         log_beats[nlog] = out_beats;
         log_sop[nlog]   = out_sop;
         log_eop[nlog]   = out_eop;
         log_data[nlog]  = out_data[31:0];
         nlog++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic set_row(input int i, input logic [63:0] a, input logic [31:0] l);
      wr({1'b0, 4'(i), 2'd0}, a[31:0]);
      wr({1'b0, 4'(i), 2'd1}, a[63:32]);
      wr({1'b0, 4'(i), 2'd2}, l);
   endtask

   task automatic clear_tbl();
      for (int i = 0; i < 16; i++) wr({1'b0, 4'(i), 2'd2}, 32'd0);
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic scan(input int b, input bit contig, output int nb, output int fb,
                       output int lb, output int tot, output int sbad);
      int cnt;
      logic [63:0] expa;
      cnt = 0; nb = 0; fb = 0; lb = 0; tot = 0; sbad = 0; expa = '0;
      for (int k = b; k < nlog; k++) begin
         if (log_sop[k]) begin
            nb++; cnt = 0;
            if (nb == 1) fb = int'(log_beats[k]);
            if (contig && nb > 1 && log_addr[k] != expa) sbad++;
            if (int'(log_addr[k][11:0]) + int'(log_beats[k]) * 32 > 4096) sbad++;
         end
         cnt++; tot++;
         if (k > b && log_data[k] != log_data[k-1] + 32'd1) sbad++;
         if (log_eop[k]) begin
            lb = int'(log_beats[k]);
            if (cnt != int'(log_beats[k])) sbad++;
            expa = log_addr[k] + 64'(cnt * 32);
         end
      end
   endtask

   // Address of the n-th burst (0-based) logged from index b
   function automatic logic [63:0] burst_addr(input int b, input int n);
      int seen;
      seen = 0;
      for (int k = b; k < nlog; k++) begin
         if (log_sop[k]) begin
            if (seen == n) return log_addr[k];
            seen++;
         end
      end
      return 64'hDEAD;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int b, nb, fb, lb, tot, sb;
      src_on = 1'b1;
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy, "R1", "busy", longint'(busy), 0);
      chk(!out_valid && !s_ready, "R1", "valid/ready", longint'({out_valid, s_ready}), 0);
      chk(done_mask == 16'h0, "R1", "done_mask", longint'(done_mask), 0);

      // Empty table: start ignored (R2)
      wr(7'h40, 32'h1);
      @(negedge clk);
      chk(!busy, "R2", "start with no valid row", longint'(busy), 0);

      // Vector table walk: R2 R3 R4 R7 R10
      for (int v = 0; v < NV; v++) begin
         clear_tbl();
         set_row(0, VECS[v].base, VECS[v].len);
         tog = VECS[v].tog;
         b = nlog;
         wr(7'h40, 32'h1);
         wait_idle();
         tog = 1'b0;
         scan(b, 1'b1, nb, fb, lb, tot, sb);
         chk(nb == int'(VECS[v].nb), "R4", $sformatf("v%0d burst count", v), nb, VECS[v].nb);
         chk(fb == int'(VECS[v].fb), "R3", $sformatf("v%0d first beats", v), fb, VECS[v].fb);
         chk(lb == int'(VECS[v].lb), "R3", $sformatf("v%0d last beats", v), lb, VECS[v].lb);
         chk(log_addr[b] == VECS[v].faddr, "R10", $sformatf("v%0d first addr", v),
             longint'(log_addr[b]), longint'(VECS[v].faddr));
         chk(tot == int'(VECS[v].len >> 5), "R10", $sformatf("v%0d total beats", v),
             tot, longint'(VECS[v].len >> 5));
         chk(sb == 0, "R7", $sformatf("v%0d stream structure errors", v), sb, 0);
         chk(done_mask == 16'h1, "R5", $sformatf("v%0d done", v), longint'(done_mask), 1);
      end
      chk(r7_bad == 0, "R7", "s_ready while out_ready low", r7_bad, 0);

      // Row skipping (R5)
      clear_tbl();
      set_row(0, 64'h10_0000, 32'd64);
      set_row(2, 64'h20_0000, 32'd32);
      set_row(5, 64'h30_0000, 32'd96);
      b = nlog;
      wr(7'h40, 32'h1);
      wait_idle();
      scan(b, 1'b0, nb, fb, lb, tot, sb);
      chk(nb == 3 && tot == 6 && sb == 0, "R5", "skip burst/beat count", nb * 100 + tot, 306);
      chk(burst_addr(b, 1) == 64'h20_0000, "R5", "second row address",
          longint'(burst_addr(b, 1)), 64'h20_0000);
      chk(burst_addr(b, 2) == 64'h30_0000, "R5", "third row address",
          longint'(burst_addr(b, 2)), 64'h30_0000);
      chk(done_mask == 16'h0025, "R5", "done after skip walk", longint'(done_mask), 16'h25);

      // Wrap mode over two rows, then stop (R6, R8)
      clear_tbl();
      set_row(0, 64'hA000, 32'd64);
      set_row(1, 64'hB000, 32'd32);
      b = nlog;
      wr(7'h40, 32'h3);
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (nlog - b >= 12) break;
      end
      wr(7'h40, 32'h2);
      wait_idle();
      chk(!busy, "R8", "idle after stop in wrap mode", longint'(busy), 0);
      chk(log_eop[nlog-1], "R8", "last beat ends a burst", longint'(log_eop[nlog-1]), 1);
      chk(burst_addr(b, 2) == 64'hA000, "R6", "wrapped back to row 0",
          longint'(burst_addr(b, 2)), 64'hA000);
      chk(burst_addr(b, 3) == 64'hB000, "R6", "then row 1 again",
          longint'(burst_addr(b, 3)), 64'hB000);
      chk(done_mask == 16'h3, "R6", "both rows done", longint'(done_mask), 3);

      // Length write clears one done bit, start clears all (R9)
      wr({1'b0, 4'd1, 2'd2}, 32'd32);
      chk(done_mask == 16'h1, "R9", "len write clears bit", longint'(done_mask), 1);
      wr(7'h40, 32'h1);
      chk(done_mask == 16'h0, "R9", "start clears all", longint'(done_mask), 0);
      wait_idle();
      chk(done_mask == 16'h3, "R9", "bits set again after walk", longint'(done_mask), 3);

      // Stop in the middle of a long row (R8)
      clear_tbl();
      set_row(0, 64'h0, 32'd4096);
      b = nlog;
      wr(7'h40, 32'h1);
      repeat (10) @(posedge clk);
      wr(7'h40, 32'h0);
      wait_idle();
      scan(b, 1'b1, nb, fb, lb, tot, sb);
      chk(tot < 128 && (tot % 8) == 0, "R8", "beats on stop", tot, 8 * nb);
      chk(done_mask == 16'h0, "R8", "row not done after stop", longint'(done_mask), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule